// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is one 8-bit general-purpose I/O port that hangs off a small microcontroller register bus. Software sets each pin's direction and its output level (or pull-up request) through bus writes. The block turns those two bits per pin, together with a system-wide pull-up kill signal, into the three controls a pad cell needs: drive enable, drive level and weak pull-up enable.

The pad levels come back in through a latch that is open while the clock is low, followed by a rising-edge flop. Software reads the pad level at the pin offset whatever the pin's direction is, so an output pin reads back its own level. A write to the pin offset does not store the data. Each 1 in the written byte inverts the matching output bit instead, so one bus write can toggle any set of pins.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After a cycle with `rst` high, the direction and output registers read 0. All pins are then undriven with no pull-up (`pad_oe`=0, `pad_pu`=0), and the pin offset reads 0 until the first capture after reset.
- R2: A write to offset 1 (direction) or offset 2 (output) stores `bus_wdata` at that clock edge. A later read of the same offset returns the stored byte.
- R3: A pin whose direction bit is 1 has `pad_oe`=1 and `pad_out` equal to its output bit: 1 drives high, 0 drives low. It has no pull-up.
- R4: A pin with direction 0 and output bit 0 is undriven with no pull-up, whatever the value of `pud_all`.
- R5: A pin with direction 0 and output bit 1 has its pull-up enabled while `pud_all` is 0.
- R6: While `pud_all` is 1, no pin of the port has its pull-up enabled. This takes effect combinationally, with no clock edge.
- R7: A write to offset 0 inverts each output bit whose written bit is 1 and leaves the bits written 0 unchanged, whatever the direction bits are. The pin offset's read value is not changed by the write.
- R8: Offset 0 reads the pad levels whatever the direction is. A level applied while the clock is high or low appears after the next rising edge and not before it.
- R9: One bus write changes at most one of the direction and output registers. Going from undriven (00) to driving high (11), or from pulled-up (01) to driving low (10), therefore passes through exactly one observable intermediate pad state.
- R10: Offset 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset: 0 pin, 1 direction, 2 output, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pud_all | input | 1 | Global pull-up disable |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_oe | output | 8 | Per-pin drive enable |
| pad_out | output | 8 | Per-pin drive level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
Register writes take effect at the capturing rising edge. The pad controls follow the registers and `pud_all` with no further delay, so the bench samples them 1 ns after that edge, or 1 ns after it changes `pud_all`. A pad level reaches the pin offset at the first rising edge after the latch has passed it. The bench applies pad changes both in the high phase and in the low phase. It reads the old value just before that edge and the new value just after it, which pins the latency to exactly one edge.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    localparam int unsigned GP_ADDR_W = 2;

    typedef enum logic [1:0] {
        GP_REG_PIN  = 2'd0,
        GP_REG_DIR  = 2'd1,
        GP_REG_OUT  = 2'd2,
        GP_REG_NONE = 2'd3
    } gp_reg_e;

    typedef enum logic [1:0] {
        GP_HIZ,
        GP_PULLED,
        GP_DRIVE_LO,
        GP_DRIVE_HI
    } gp_mode_e;

    typedef struct packed {
        logic drive;
        logic level;
        logic pull;
    } gp_pin_ctl_t;

    function automatic gp_mode_e gp_mode(input logic dir, input logic port,
                                         input logic pud_all);
        gp_mode_e m;
        if (dir)
            m = port ? GP_DRIVE_HI : GP_DRIVE_LO;
        else if (port && !pud_all)
            m = GP_PULLED;
        else
            m = GP_HIZ;
        return m;
    endfunction

    function automatic gp_pin_ctl_t gp_ctl(input gp_mode_e m);
        gp_pin_ctl_t c;
        c = '0;
        unique case (m)
            GP_PULLED:   c.pull  = 1'b1;
            GP_DRIVE_LO: c.drive = 1'b1;
            GP_DRIVE_HI: begin
                c.drive = 1'b1;
                c.level = 1'b1;
            end
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gp_cfg_regs.sv
`timescale 1ns/1ps
module gp_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [GP_ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]     wdata,
    output logic [WIDTH-1:0]     dir_q,
    output logic [WIDTH-1:0]     port_q
);
    gp_reg_e sel;
    assign sel = gp_reg_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            port_q <= '0;
        end else if (we) begin
            unique case (sel)
                GP_REG_PIN: port_q <= port_q ^ wdata;
                GP_REG_DIR: dir_q  <= wdata;
                GP_REG_OUT: port_q <= wdata;
                default:    ;
            endcase
        end
    end

    // R7
    toggle_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && sel == GP_REG_PIN) |=> port_q == ($past(port_q) ^ $past(wdata)));

    // R9
    one_reg_per_write_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> !((dir_q != $past(dir_q)) && (port_q != $past(port_q))));

    // R10
    unused_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (we && sel == GP_REG_NONE) |=> ($stable(dir_q) && $stable(port_q)));

endmodule

// File: rtl/gp_in_sync.sv
`timescale 1ns/1ps
module gp_in_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pin_q
);
    logic [WIDTH-1:0] lat_q;

    // open while clk is low, closed while it is high
    always_latch begin
        if (!clk)
            lat_q <= pad_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pin_q <= '0;
        else
            pin_q <= lat_q;
    end

    // R8
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pin_q == $past(pad_in));

endmodule

// File: rtl/gp_pin_decode.sv
`timescale 1ns/1ps
module gp_pin_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] port,
    input  logic             pud_all,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        gp_pin_ctl_t ctl;
        assign ctl    = gp_ctl(gp_mode(dir[i], port[i], pud_all));
        assign oe[i]  = ctl.drive;
        assign lvl[i] = ctl.level;
        assign pu[i]  = ctl.pull;
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GP_ADDR_W-1:0] bus_addr,
    input  logic                 bus_we,
    input  logic [WIDTH-1:0]     bus_wdata,
    output logic [WIDTH-1:0]     bus_rdata,
    input  logic                 pud_all,
    input  logic [WIDTH-1:0]     pad_in,
    output logic [WIDTH-1:0]     pad_oe,
    output logic [WIDTH-1:0]     pad_out,
    output logic [WIDTH-1:0]     pad_pu
);
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] port_q;
    logic [WIDTH-1:0] pin_q;

    gp_cfg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .port_q(port_q)
    );

    gp_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pad_in(pad_in),
        .pin_q (pin_q)
    );

    gp_pin_decode #(.WIDTH(WIDTH)) u_dec (
        .dir    (dir_q),
        .port   (port_q),
        .pud_all(pud_all),
        .oe     (pad_oe),
        .lvl    (pad_out),
        .pu     (pad_pu)
    );

    always_comb begin
        unique case (gp_reg_e'(bus_addr))
            GP_REG_PIN: bus_rdata = pin_q;
            GP_REG_DIR: bus_rdata = dir_q;
            GP_REG_OUT: bus_rdata = port_q;
            default:    bus_rdata = '0;
        endcase
    end

    // R3
    drive_excludes_pull_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_pu) == '0);

    // R6
    global_pull_off_chk: assert property (@(posedge clk) disable iff (rst)
        pud_all |-> pad_pu == '0);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_pu == '0));

endmodule

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pud_all = 1'b0;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out, pad_pu;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pud_all(pud_all),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd1, v); chk("R1 dir", v, 8'h00);
        rd(2'd2, v); chk("R1 out", v, 8'h00);
        rd(2'd0, v); chk("R1 pin", v, 8'h00);
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 pu", pad_pu, 8'h00);
    endtask

    task automatic t_regs_and_table;
        logic [7:0] v;
        // bits 7:6 drive hi, 5:4 drive lo, 3:2 pulled, 1:0 hi-z
        wr(2'd1, 8'hF0);
        wr(2'd2, 8'hCC);
        rd(2'd1, v); chk("R2 dir", v, 8'hF0);
        rd(2'd2, v); chk("R2 out", v, 8'hCC);
        chk("R3 oe", pad_oe, 8'hF0);
        chk("R3 out", pad_out & pad_oe, 8'hC0);
        chk("R5 pu", pad_pu, 8'h0C);
        pud_all = 1'b1; #1;
        chk("R6 pu", pad_pu, 8'h00);
        chk("R4 pu", pad_pu & 8'h03, 8'h00);
        chk("R4 oe", pad_oe & 8'h03, 8'h00);
        pud_all = 1'b0; #1;
        chk("R5 pu back", pad_pu, 8'h0C);
        chk("R4 pu", pad_pu & 8'h03, 8'h00);
    endtask

    task automatic t_toggle;
        logic [7:0] v;
        pad_in = 8'h3C;
        wr(2'd1, 8'hF0);
        wr(2'd2, 8'h00);
        rd(2'd0, v); chk("R8 pin pre", v, 8'h3C);
        wr(2'd0, 8'hA5);
        rd(2'd2, v); chk("R7 out", v, 8'hA5);
        chk("R7 pad_out", pad_out & pad_oe, 8'hA0);
        chk("R7 pu", pad_pu, 8'h05);
        wr(2'd0, 8'h0F);
        rd(2'd2, v); chk("R7 out2", v, 8'hAA);
        rd(2'd1, v); chk("R7 dir kept", v, 8'hF0);
        rd(2'd0, v); chk("R7 pin kept", v, 8'h3C);
    endtask

    task automatic t_sync;
        logic [7:0] v;
        wr(2'd1, 8'hFF);
        bus_addr = 2'd0;
        @(posedge clk); #1;
        pad_in = 8'h5A;                 // high phase
        #1; chk("R8 hi before", bus_rdata, 8'h3C);
        @(negedge clk); #2;
        chk("R8 hi still", bus_rdata, 8'h3C);
        @(posedge clk); #1;
        chk("R8 hi after", bus_rdata, 8'h5A);
        @(negedge clk); #1;
        pad_in = 8'hC3;                 // low phase
        #1; chk("R8 lo before", bus_rdata, 8'h5A);
        @(posedge clk); #1;
        rd(2'd0, v); chk("R8 lo after", v, 8'hC3);
    endtask

    task automatic t_transition;
        logic [7:0] v;
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h01);                // 00 -> 01
        chk("R9 mid oe", pad_oe, 8'h00);
        chk("R9 mid pu", pad_pu, 8'h01);
        wr(2'd1, 8'h01);                // 01 -> 11
        chk("R9 end oe", pad_oe, 8'h01);
        chk("R9 end out", pad_out, 8'h01);
        chk("R9 end pu", pad_pu, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h01);                // pulled
        wr(2'd2, 8'h00);                // 01 -> 00
        chk("R9 mid2 pu", pad_pu, 8'h00);
        chk("R9 mid2 oe", pad_oe, 8'h00);
        wr(2'd1, 8'h01);                // 00 -> 10
        chk("R9 lo oe", pad_oe, 8'h01);
        chk("R9 lo out", pad_out, 8'h00);
        rd(2'd2, v); chk("R9 out kept", v, 8'h00);
    endtask

    task automatic t_unused;
        logic [7:0] v;
        wr(2'd1, 8'h3A);
        wr(2'd2, 8'h5C);
        wr(2'd3, 8'hFF);
        rd(2'd3, v); chk("R10 read", v, 8'h00);
        rd(2'd1, v); chk("R10 dir", v, 8'h3A);
        rd(2'd2, v); chk("R10 out", v, 8'h5C);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_regs_and_table();
        t_toggle();
        t_sync();
        t_transition();
        t_unused();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule